// File: doc/BRIEF.md
# I2C Byte-Command Master

This block is a memory-mapped I2C bus master that moves exactly one byte per software command. A single write to the command register carries the byte together with flags that ask for a START (or repeated START), a STOP, and the level the master leaves on SDA in the acknowledge slot. The block then sequences the open-drain SCL and SDA lines through an optional start, eight data bits sent most significant bit first, and one acknowledge slot. Between bytes it holds SCL low so that the bus stays owned.

Completion is reported only through a level interrupt. There is no pollable busy flag. A receive register returns the byte sampled from SDA, the SDA level seen in the acknowledge slot, an arbitration-lost flag and a bus-owned status bit. SCL timing comes from a register that holds the full SCL period and the SCL high time, both counted in input-clock cycles. A control register provides an active-low controller reset and an output enable. Software sets 0x1 while it changes the timing and then 0x3 to run.

The controller is a state machine with these states: IDLE, RS_LOW, ST_HIGH, ST_HOLD, BIT_LOW, BIT_HIGH, ACK_LOW, ACK_HIGH, ACK_END, SP_LOW, SP_HIGH and SP_REL.
- IDLE on a command goes to SP_LOW if the STOP flag is set. If the START flag is set it goes to RS_LOW when the bus is held, or to ST_HIGH when the bus is free. Otherwise it goes to BIT_LOW.
- RS_LOW goes to ST_HIGH, ST_HIGH to ST_HOLD, and ST_HOLD to BIT_LOW.
- BIT_LOW goes to BIT_HIGH. BIT_HIGH returns to BIT_LOW until eight bits are done, then goes to ACK_LOW.
- ACK_LOW goes to ACK_HIGH, ACK_HIGH to ACK_END, and ACK_END to IDLE.
- SP_LOW goes to SP_HIGH, SP_HIGH to SP_REL, and SP_REL to IDLE.

Each low state lasts period minus high cycles and each high state lasts high cycles. ACK_END is the exception: it ends at the middle of the low time. Both times must be at least 3 cycles.

Top module: `i2c_byte_master`

## Requirements
- R1: A command-register write (address 0) accepted in IDLE starts one operation. Command bit 10 requests a START, bit 9 a STOP, bit 8 releases SDA in the acknowledge slot, and bits 7:0 are the byte, sent MSB first with one bit per SCL period.
- R2: A command with bit 9 set produces only a STOP: SDA goes low while SCL is low, SCL is released, and then SDA rises while SCL is high. No data clock is generated, bits 10 and 7:0 are ignored, and both lines end released.
- R3: In the acknowledge slot the master releases SDA when command bit 8 is 1 and drives it low when bit 8 is 0.
- R4: The receive register (address 1) returns the sampled byte in bits 7:0, the acknowledge-slot SDA level in bit 11 (1 = not acknowledged), arbitration lost in bit 9, and bit 12 = 1 while the master holds the bus. All other bits read 0, and the register reads 0 after reset.
- R5: The timing register (address 2) holds the SCL period in bits 15:0 and the SCL high time in bits 31:16. Within a byte, consecutive SCL rising edges are exactly one period apart and SCL stays high for exactly the high time.
- R6: In the control register (address 3), bit 0 = 0 holds the controller in reset, so commands are ignored and the interrupt stays low. Bit 1 = 0 keeps both line drivers off while the controller still runs. Reset value is 0.
- R7: The interrupt rises once a byte (about nine SCL periods) or a STOP completes. It stays high until the next accepted command write, which clears it in the next cycle.
- R8: A START requested while the master holds the bus produces a repeated START with no STOP in between: SDA is released while SCL is low, SCL rises, and then SDA falls while SCL is high.
- R9: After an address byte whose bit 0 is 1, the following data bytes release SDA for all eight data bits so that the slave can drive them, until the next START or STOP.
- R10: If SDA reads low at the SCL-high midpoint while the master sends a 1 (not in read mode), the master releases both lines for the rest of the byte, sets receive bit 9, does not keep the bus held, and still raises the interrupt.
- R11: A command write that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 receive, 2 timing, 3 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Completion interrupt, level |

## Verification
A wrong state or phase count shows on the bus within one SCL period. Possible symptoms are an SCL edge spaced other than the programmed period or high time, an SDA change while SCL is high that decodes as a spurious start or stop, or a byte that decodes to the wrong value. A wrong read-mode or acknowledge flag corrupts the byte read back at the next interrupt, because the master then fights the slave on SDA. A stuck held-bus flag shows as SCL still pulled low after a STOP, and a lost arbitration flag that is not honoured shows as an output enable asserted during the rest of that byte.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
    localparam int CMD_W  = 11;
    localparam int BYTE_W = 8;
    localparam int FLD_W  = 16;

    localparam int CMD_STA  = 10;
    localparam int CMD_STO  = 9;
    localparam int CMD_AREL = 8;

    localparam logic [1:0] ADDR_CMD  = 2'd0;
    localparam logic [1:0] ADDR_RX   = 2'd1;
    localparam logic [1:0] ADDR_TIME = 2'd2;
    localparam logic [1:0] ADDR_CTL  = 2'd3;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RS_LOW, ST_ST_HIGH, ST_ST_HOLD,
        ST_BIT_LOW, ST_BIT_HIGH, ST_ACK_LOW, ST_ACK_HIGH, ST_ACK_END,
        ST_SP_LOW, ST_SP_HIGH, ST_SP_REL
    } bm_state_t;
endpackage

// File: rtl/i2c_bm_regs.sv
module i2c_bm_regs
    import i2c_bm_pkg::*;
#(
    parameter int DW         = 32,
    parameter int DEF_PERIOD = 250,
    parameter int DEF_HIGH   = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [DW-1:0]     rx_word,
    output logic [DW-1:0]     reg_rdata,
    output logic [FLD_W-1:0]  period,
    output logic [FLD_W-1:0]  high,
    output logic              run,
    output logic              out_en,
    output logic              cmd_wr,
    output logic [CMD_W-1:0]  cmd
);
    localparam logic [DW-1:0] TIME_RST = DW'({16'(DEF_HIGH), 16'(DEF_PERIOD)});

    logic [DW-1:0] time_q;
    logic [1:0]    ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= TIME_RST;
            ctl_q  <= 2'b00;
        end else if (reg_we) begin
            if (reg_addr == ADDR_TIME) time_q <= reg_wdata;
            if (reg_addr == ADDR_CTL)  ctl_q  <= reg_wdata[1:0];
        end
    end

    assign period = time_q[FLD_W-1:0];
    assign high   = time_q[2*FLD_W-1:FLD_W];
    assign run    = ctl_q[0];
    assign out_en = ctl_q[1];
    assign cmd_wr = reg_we && (reg_addr == ADDR_CMD);
    assign cmd    = reg_wdata[CMD_W-1:0];

    always_comb begin
        unique case (reg_addr)
            ADDR_RX:   reg_rdata = rx_word;
            ADDR_TIME: reg_rdata = time_q;
            ADDR_CTL:  reg_rdata = {{(DW-2){1'b0}}, ctl_q};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_bm_phase.sv
module i2c_bm_phase
    import i2c_bm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             is_low,
    input  logic [FLD_W-1:0] period,
    input  logic [FLD_W-1:0] high,
    output logic             mid,
    output logic             last
);
    logic [FLD_W-1:0] cnt;
    logic [FLD_W-1:0] len;

    assign len  = is_low ? (period - high) : high;
    assign mid  = (cnt == (len >> 1));
    assign last = (cnt == (len - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (adv) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_bm_fsm.sv
module i2c_bm_fsm
    import i2c_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              mid,
    input  logic              last,
    input  logic              sda_in,
    output logic              adv,
    output logic              is_low,
    output logic              scl_low,
    output logic              sda_low,
    output logic              irq,
    output logic              held,
    output logic              lost,
    output logic              idle,
    output logic              rx_nack,
    output logic              rx_lost,
    output logic [BYTE_W-1:0] rx_byte
);
    bm_state_t         state, state_n;
    logic [BYTE_W-1:0] tx_sh, rx_sh;
    logic [2:0]        bitn;
    logic              ack_rel, sda_q, rd_mode, rd_next, go;

    assign go   = cmd_wr && (state == ST_IDLE);
    assign idle = (state == ST_IDLE);
    assign adv  = (state_n != state) || (state == ST_IDLE);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:     if (go) state_n = cmd[CMD_STO] ? ST_SP_LOW :
                                           cmd[CMD_STA] ? (held ? ST_RS_LOW : ST_ST_HIGH) :
                                           ST_BIT_LOW;
            ST_RS_LOW:   if (last) state_n = ST_ST_HIGH;
            ST_ST_HIGH:  if (last) state_n = ST_ST_HOLD;
            ST_ST_HOLD:  if (last) state_n = ST_BIT_LOW;
            ST_BIT_LOW:  if (last) state_n = ST_BIT_HIGH;
            ST_BIT_HIGH: if (last) state_n = (bitn == 3'd7) ? ST_ACK_LOW : ST_BIT_LOW;
            ST_ACK_LOW:  if (last) state_n = ST_ACK_HIGH;
            ST_ACK_HIGH: if (last) state_n = ST_ACK_END;
            ST_ACK_END:  if (mid)  state_n = ST_IDLE;
            ST_SP_LOW:   if (last) state_n = ST_SP_HIGH;
            ST_SP_HIGH:  if (last) state_n = ST_SP_REL;
            ST_SP_REL:   if (last) state_n = ST_IDLE;
            default:               state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= ST_IDLE;
        else if (!run) state <= ST_IDLE;
        else           state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0; rx_sh <= '0; rx_byte <= '0; bitn <= '0;
            ack_rel <= 1'b0; sda_q <= 1'b0; held <= 1'b0; lost <= 1'b0;
            rd_mode <= 1'b0; rd_next <= 1'b0; irq <= 1'b0;
            rx_nack <= 1'b0; rx_lost <= 1'b0;
        end else if (!run) begin
            sda_q <= 1'b0; held <= 1'b0; lost <= 1'b0; irq <= 1'b0;
            rd_mode <= 1'b0; rd_next <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (go) begin
                    irq <= 1'b0; lost <= 1'b0; bitn <= '0;
                    tx_sh <= cmd[BYTE_W-1:0]; ack_rel <= cmd[CMD_AREL];
                    if (cmd[CMD_STA] && !cmd[CMD_STO]) begin
                        rd_mode <= 1'b0; rd_next <= cmd[0];
                    end
                end
                ST_RS_LOW:  if (mid)  sda_q <= 1'b0;
                ST_ST_HIGH: if (last) sda_q <= 1'b1;
                ST_ST_HOLD: ;
                ST_BIT_LOW: if (mid)  sda_q <= !lost && !rd_mode && !tx_sh[BYTE_W-1];
                ST_BIT_HIGH: begin
                    if (mid) begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], sda_in};
                        if (!rd_mode && tx_sh[BYTE_W-1] && !sda_in && !lost) begin
                            lost  <= 1'b1;
                            sda_q <= 1'b0;
                        end
                    end
                    if (last) begin
                        tx_sh <= tx_sh << 1;
                        bitn  <= bitn + 3'd1;
                    end
                end
                ST_ACK_LOW:  if (mid) sda_q   <= !lost && !ack_rel;
                ST_ACK_HIGH: if (mid) rx_nack <= sda_in;
                ST_ACK_END: if (mid) begin
                    sda_q <= 1'b0; irq <= 1'b1; held <= !lost;
                    rd_mode <= rd_next; rx_byte <= rx_sh; rx_lost <= lost;
                end
                ST_SP_LOW:  if (mid)  sda_q <= 1'b1;
                ST_SP_HIGH: if (last) sda_q <= 1'b0;
                ST_SP_REL: if (last) begin
                    held <= 1'b0; irq <= 1'b1; rd_mode <= 1'b0; rd_next <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        is_low  = 1'b0;
        scl_low = 1'b0;
        unique case (state)
            ST_IDLE:                    scl_low = held;
            ST_RS_LOW, ST_SP_LOW:       begin is_low = 1'b1; scl_low = 1'b1; end
            ST_BIT_LOW, ST_ACK_LOW,
            ST_ACK_END:                 begin is_low = 1'b1; scl_low = !lost; end
            default:                    ;
        endcase
        sda_low = sda_q;
    end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int DW         = 32,
    parameter int DEF_PERIOD = 250,
    parameter int DEF_HIGH   = 125
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          sda_in,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          irq
);
    localparam int PAD_W = DW - 13;

    logic [FLD_W-1:0]  period, high;
    logic [CMD_W-1:0]  cmd;
    logic [BYTE_W-1:0] rx_byte;
    logic [DW-1:0]     rx_word;
    logic run_w, out_en_w, cmd_wr, mid, last, adv, is_low;
    logic scl_low, sda_low, held, lost_w, idle_w, rx_nack, rx_lost;

    assign rx_word = {{PAD_W{1'b0}}, held, rx_nack, 1'b0, rx_lost, 1'b0, rx_byte};

    i2c_bm_regs #(.DW(DW), .DEF_PERIOD(DEF_PERIOD), .DEF_HIGH(DEF_HIGH)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rx_word(rx_word), .reg_rdata(reg_rdata),
        .period(period), .high(high), .run(run_w), .out_en(out_en_w),
        .cmd_wr(cmd_wr), .cmd(cmd)
    );

    i2c_bm_phase u_phase (
        .clk(clk), .rst_n(rst_n), .adv(adv), .is_low(is_low),
        .period(period), .high(high), .mid(mid), .last(last)
    );

    i2c_bm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run_w), .cmd_wr(cmd_wr), .cmd(cmd),
        .mid(mid), .last(last), .sda_in(sda_in), .adv(adv), .is_low(is_low),
        .scl_low(scl_low), .sda_low(sda_low), .irq(irq), .held(held),
        .lost(lost_w), .idle(idle_w), .rx_nack(rx_nack), .rx_lost(rx_lost),
        .rx_byte(rx_byte)
    );

    assign scl_oe = out_en_w && scl_low;
    assign sda_oe = out_en_w && sda_low;
endmodule

// File: rtl/i2c_bm_chk.sv
module i2c_bm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [1:0] reg_addr,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       irq,
    input logic       run,
    input logic       out_en,
    input logic       idle,
    input logic       lost
);
    // R6
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (!scl_oe && !sda_oe));

    // R6
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!irq && idle));

    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd0 && run && idle) |=> !irq);

    // R7
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> idle);

    // R10
    lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_byte_master i2c_bm_chk chk_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq), .run(run_w),
    .out_en(out_en_w), .idle(idle_w), .lost(lost_w)
);

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        scl_oe, sda_oe, irq;
    logic        sl_low = 1'b0, jam = 1'b0;
    logic        scl_line, sda_line;

    int nchk = 0, nerr = 0, cyc = 0;
    int starts = 0, stops = 0, nbytes = 0, mbit = 0, t_rise = 0;
    int per_bad = 0, hi_bad = 0, p_exp = 8, h_exp = 4;
    logic [7:0] mbyte = '0, sl_data = '0;
    logic mack = 1'b0, first = 1'b1, rdm = 1'b0, sl_ack_en = 1'b1;
    logic pscl = 1'b1, psda = 1'b1, tmon = 1'b0, oe_seen = 1'b0;

    always #10 clk = ~clk;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || sl_low || jam);

    i2c_byte_master dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
    );

    // bus monitor and simple slave
    always @(negedge clk) begin
        cyc++;
        if (scl_oe || sda_oe) oe_seen = 1'b1;
        if (scl_line && pscl && psda && !sda_line) begin
            starts++; mbit = 0; first = 1'b1; rdm = 1'b0;
        end else if (scl_line && pscl && !psda && sda_line) begin
            stops++;
        end
        if (scl_line && !pscl) begin
            if (tmon && mbit > 0 && mbit < 9 && (cyc - t_rise) != p_exp) per_bad++;
            t_rise = cyc;
            if (mbit < 8) mbyte = {mbyte[6:0], sda_line};
            else          mack  = sda_line;
            mbit++;
        end
        if (!scl_line && pscl) begin
            if (tmon && mbit >= 1 && (cyc - t_rise) != h_exp) hi_bad++;
            if (mbit == 9) begin
                mbit = 0; nbytes++;
                if (first) begin rdm = mbyte[0]; first = 1'b0; end
            end
        end
        if (!scl_line) begin
            if (rdm && !first && mbit < 8)  sl_low = !sl_data[7 - mbit];
            else if (mbit == 8 && !(rdm && !first)) sl_low = sl_ack_en;
            else                              sl_low = 1'b0;
        end
        pscl = scl_line;
        psda = sda_line;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_irq(output int lat);
        lat = 0;
        while (!irq && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
        if (!irq) begin
            nchk++; nerr++;
            $display("FAIL R7 interrupt timeout actual=0 expected=1");
        end
    endtask

    task automatic cmd_wait(input logic [31:0] c, output int lat);
        wr(2'd0, c);
        wait_irq(lat);
    endtask

    task automatic set_timing(input int p, input int h);
        wr(2'd3, 32'h1);
        wr(2'd2, (h << 16) | p);
        wr(2'd3, 32'h3);
        p_exp = p; h_exp = h;
    endtask

    initial begin : main
        logic [31:0] v;
        int lat, s0, p0, nb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(2'd1, v); chk(v == 0, "R4 receive reset", v, 0);
        rd(2'd2, v); chk(v == ((125 << 16) | 250), "R5 timing reset", v, (125 << 16) | 250);
        rd(2'd3, v); chk(v == 0, "R6 control reset", v, 0);
        chk(!scl_oe && !sda_oe && !irq, "R6 outputs at reset", {scl_oe, sda_oe, irq}, 0);

        // R6: controller held in reset ignores commands
        wr(2'd0, 32'h5A0);
        repeat (300) @(negedge clk);
        chk(irq == 0, "R6 command ignored in reset", irq, 0);
        chk(oe_seen == 0, "R6 no drive in reset", oe_seen, 0);

        // R6: running with drivers off
        wr(2'd3, 32'h1);
        wr(2'd2, (4 << 16) | 8);
        p_exp = 8; h_exp = 4;
        cmd_wait(32'h5A0, lat);
        rd(2'd1, v);
        chk(v[11] == 1, "R6 drivers off gives nack", v[11], 1);
        chk(oe_seen == 0, "R6 drivers off", oe_seen, 0);
        cmd_wait(32'h200, lat);
        wr(2'd3, 32'h3);

        // R1 R3 R4 R5 R7: write sweep over all byte values
        tmon = 1'b1;
        sl_ack_en = 1'b1;
        cmd_wait(32'h5A0, lat);
        rd(2'd1, v);
        chk(starts == 1, "R1 start seen", starts, 1);
        chk(mbyte == 8'hA0, "R1 address byte", mbyte, 8'hA0);
        chk(v[11] == 0, "R4 address acked", v[11], 0);
        chk(v[12] == 1, "R4 bus held", v[12], 1);
        for (int i = 0; i < 256; i++) begin
            sl_ack_en = (i % 3) != 0;
            wr(2'd0, 32'h100 | i);
            chk(irq == 0, "R7 irq cleared by command", irq, 0);
            wait_irq(lat);
            chk(lat >= 9 * 8 - 2 && lat <= 9 * 8 + 6, "R7 byte duration", lat, 9 * 8);
            rd(2'd1, v);
            chk(mbyte == i[7:0], "R1 byte on bus", mbyte, i);
            chk(v[11] == ((i % 3) == 0), "R3 R4 slave ack level", v[11], (i % 3) == 0);
            chk(v[9] == 0, "R10 no loss", v[9], 0);
        end

        // R8: repeated start into read
        sl_ack_en = 1'b1;
        s0 = starts; p0 = stops;
        cmd_wait(32'h5A1, lat);
        chk(starts == s0 + 1, "R8 repeated start", starts, s0 + 1);
        chk(stops == p0, "R8 no stop before restart", stops, p0);
        chk(mbyte == 8'hA1, "R8 read address", mbyte, 8'hA1);

        // R9 R3: read sweep
        for (int i = 0; i < 256; i++) begin
            sl_data = 8'(i * 37 + 5);
            cmd_wait((i == 255) ? 32'h100 : 32'h000, lat);
            rd(2'd1, v);
            chk(v[7:0] == 8'(i * 37 + 5), "R9 read byte", v[7:0], 8'(i * 37 + 5));
            chk(mack == (i == 255), "R3 master ack level", mack, i == 255);
        end

        // R2: stop with other bits set
        nb = nbytes;
        cmd_wait(32'h7A5, lat);
        chk(stops == p0 + 1, "R2 stop seen", stops, p0 + 1);
        chk(nbytes == nb, "R2 no data clocked", nbytes, nb);
        chk(!scl_oe && !sda_oe, "R2 bus released", {scl_oe, sda_oe}, 0);
        rd(2'd1, v);
        chk(v[12] == 0, "R4 bus not held after stop", v[12], 0);
        repeat (50) @(negedge clk);
        chk(irq == 1, "R7 irq level holds", irq, 1);
        chk(per_bad == 0, "R5 period cfg1", per_bad, 0);
        chk(hi_bad == 0, "R5 high time cfg1", hi_bad, 0);

        // R5: second timing configuration
        set_timing(11, 5);
        rd(2'd2, v);
        chk(v == ((5 << 16) | 11), "R5 timing readback", v, (5 << 16) | 11);
        cmd_wait(32'h5A0, lat);
        for (int i = 0; i < 16; i++) begin
            cmd_wait(32'h100 | (i * 17), lat);
            chk(mbyte == 8'(i * 17), "R1 byte cfg2", mbyte, 8'(i * 17));
        end
        cmd_wait(32'h300, lat);
        chk(per_bad == 0, "R5 period cfg2", per_bad, 0);
        chk(hi_bad == 0, "R5 high time cfg2", hi_bad, 0);

        // R11: command while busy is ignored
        cmd_wait(32'h5A0, lat);
        nb = nbytes;
        wr(2'd0, 32'h1C3);
        repeat (20) @(negedge clk);
        wr(2'd0, 32'h13C);
        wait_irq(lat);
        chk(mbyte == 8'hC3, "R11 first byte kept", mbyte, 8'hC3);
        repeat (300) @(negedge clk);
        chk(nbytes == nb + 1, "R11 one byte only", nbytes, nb + 1);
        cmd_wait(32'h300, lat);

        // R10: arbitration loss
        tmon = 1'b0;
        cmd_wait(32'h5A0, lat);
        jam = 1'b1;
        cmd_wait(32'h1F0, lat);
        rd(2'd1, v);
        chk(v[9] == 1, "R10 lost flag", v[9], 1);
        chk(v[12] == 0, "R10 bus not held", v[12], 0);
        chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
        jam = 1'b0;
        cmd_wait(32'h300, lat);
        cmd_wait(32'h5A0, lat);
        rd(2'd1, v);
        chk(v[9] == 0, "R10 flag clears on next byte", v[9], 0);
        cmd_wait(32'h300, lat);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule